// File: doc/BRIEF.md
# Receive Performance Counter Snapshot Controller

This block keeps a bank of live performance counters for the receive side of one serial interface. Each counter belongs to one event input, such as good frames, errored frames or received bytes. Every event input is a single-cycle pulse, and each pulse adds one to its counter. Each counter stops at its all-ones value and does not wrap.

A host drives the block through a small register port. To capture an interval, the host writes 1 to a control bit. On the 0-to-1 change of that bit, the block copies every live counter into a holding register and clears the live counters in the same clock edge. One cycle later it raises a completion flag. The host reads the held values at its own pace. It then writes the control bit back to 0, which drops the flag and closes the handshake. An event that lands in the capture cycle is not lost: it counts as the first event of the new interval.

Top module: `rx_pm_snapshot`

## Requirements
- R1: A capture happens only when the control bit changes from 0 to 1. Keeping the bit at 1 never starts another capture, and writing 1 while it is already 1 starts none either.
- R2: On a capture, every holding register takes the value its live counter had just before that edge. All live counters restart from zero on the same edge.
- R3: An event pulse that is present in the capture cycle is counted as 1 in the new interval.
- R4: A live counter that has reached 2^CNT_W-1 stays there when further events arrive, until the next capture.
- R5: The control write takes effect at edge E1, and the capture happens at edge E2. The status bit becomes 1 at edge E3. A status read sampled at E3 returns 0, and one sampled at E4 returns 1. The new held values are readable from E3 on.
- R6: The status bit stays 1 while the control bit stays 1. It returns to 0 on the edge after the control bit is written to 0.
- R7: The holding registers keep their values until the next capture.
- R8: Register map, in bytes of address: 0x120 holds the control bit at bit 0, which can be read and written. 0x121 holds the status bit at bit 0, which is read-only, and writes to 0x121 are ignored. Address 0x124+i returns holding register i, zero-extended. Every other bit of 0x120 and 0x121 reads 0, and their written values are ignored. Any unmapped address reads 0.
- R9: After reset, the control bit, the status bit, all live counters and all holding registers are 0.
- R10: A read request sampled at one edge returns its data on `rd_data` with `rd_valid` high during the following cycle. `rd_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_CNT | Single-cycle increment pulses, one per counter |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
Two functions can fall in the same cycle: the capture and an increment pulse. The bench drives event pulses in the exact cycle between the control write and the capture edge. It then takes a second capture with no events in between. The counter that pulsed must read back 1, and the previous held values must exclude that pulse. A second case starts a capture from a counter that is pinned at all-ones. This checks that saturation does not block the clear.

// File: rtl/rx_pm_snapshot_pkg.sv
package rx_pm_snapshot_pkg;
  localparam int unsigned CTRL_OFS = 'h120;
  localparam int unsigned STAT_OFS = 'h121;
  localparam int unsigned HOLD_OFS = 'h124;
endpackage

// File: rtl/rx_pm_snap_ctrl.sv
module rx_pm_snap_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic ctrl_wbit,
  output logic ctrl,
  output logic snap,
  output logic done
);
  logic ctrl_q;
  logic snap_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= 1'b0;
      ctrl_q <= 1'b0;
      snap_d <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (ctrl_we) ctrl <= ctrl_wbit;
      ctrl_q <= ctrl;
      snap_d <= snap;
      done   <= ctrl & (snap_d | done);
    end
  end

  assign snap = ctrl & ~ctrl_q;

  assert_done_after_snap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(snap, 2));

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl |=> !done);

  assert_no_repeat_R1: assert property (@(posedge clk) disable iff (rst)
    (ctrl && $past(ctrl)) |-> !snap);
endmodule

// File: rtl/rx_pm_cnt_bank.sv
module rx_pm_cnt_bank #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CNT-1:0]              evt,
  input  logic                            snap,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i]  <= '0;
        hold[i] <= '0;
      end else if (snap) begin
        hold[i] <= cnt[i];
        cnt[i]  <= CNT_W'(evt[i]);
      end else if (evt[i] && cnt[i] != CNT_MAX) begin
        cnt[i] <= cnt[i] + 1'b1;
      end
    end

    assert_clear_and_keep_R3: assert property (@(posedge clk) disable iff (rst)
      snap |=> cnt[i] == CNT_W'($past(evt[i])));

    assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
      (!snap && cnt[i] == CNT_MAX) |=> cnt[i] == CNT_MAX);
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(hold));
endmodule

// File: rtl/rx_pm_regif.sv
module rx_pm_regif
  import rx_pm_snapshot_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  input  logic                            ctrl,
  input  logic                            done,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   hold,
  output logic                            ctrl_we,
  output logic                            ctrl_wbit,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            rd_valid
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic [DATA_W-1:0] rd_mux;
  logic              was_ctrl_rd;

  assign ctrl_we   = reg_wr && reg_addr == A_CTRL;
  assign ctrl_wbit = reg_wdata[0];

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CTRL) rd_mux = DATA_W'(ctrl);
    if (reg_addr == A_STAT) rd_mux = DATA_W'(done);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(HOLD_OFS + i)) rd_mux = DATA_W'(hold[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      was_ctrl_rd <= 1'b0;
    end else begin
      rd_valid    <= reg_rd;
      was_ctrl_rd <= reg_rd && reg_addr == A_CTRL;
      if (reg_rd) rd_data <= rd_mux;
    end
  end

  assert_ctrl_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    was_ctrl_rd |-> rd_data[DATA_W-1:1] == '0);

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !rd_valid);
endmodule

// File: rtl/rx_pm_snapshot.sv
module rx_pm_snapshot #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] evt,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);
  logic ctrl, snap, done, ctrl_we, ctrl_wbit;
  logic [NUM_CNT-1:0][CNT_W-1:0] hold;

  rx_pm_snap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wbit(ctrl_wbit),
    .ctrl(ctrl), .snap(snap), .done(done)
  );

  rx_pm_cnt_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .evt(evt), .snap(snap), .hold(hold)
  );

  rx_pm_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl(ctrl), .done(done), .hold(hold),
    .ctrl_we(ctrl_we), .ctrl_wbit(ctrl_wbit), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/rx_pm_snapshot_test.sv
module rx_pm_snapshot_test;
  localparam int N = 3;
  localparam int CW = 8;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MAXV = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] evt = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  int checks = 0, failures = 0;
  bit finished = 0;
  int mc[N];
  int mh[N];
  bit m_ctrl = 0, m_done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rx_pm_snapshot #(.NUM_CNT(N), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .evt(evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected rd_valid actual=%0d expected=0", rd_valid);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s actual=%0h expected=%0h", t, rd_data, e);
        end
      end
    end
  end

  function automatic int sat_inc(int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rd(int addr, logic [DW-1:0] exp, string tag);
    reg_rd = 1'b1; reg_addr = AW'(addr);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] mask, int n);
    repeat (n) begin
      evt = mask;
      for (int i = 0; i < N; i++) if (mask[i]) mc[i] = sat_inc(mc[i]);
      @(posedge clk); @(negedge clk);
      evt = '0;
    end
  endtask

  task automatic wr(int addr, logic [DW-1:0] data);
    reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // control write; mask drives events in the cycle before the capture edge
  task automatic ctrl_wr(logic [DW-1:0] data, logic [N-1:0] mask, bit settle);
    bit rising;
    rising = data[0] && !m_ctrl;
    wr('h120, data);
    evt = mask;
    if (rising) begin
      for (int i = 0; i < N; i++) begin
        mh[i] = mc[i];
        mc[i] = mask[i] ? 1 : 0;
      end
    end else begin
      for (int i = 0; i < N; i++) if (mask[i]) mc[i] = sat_inc(mc[i]);
    end
    m_ctrl = data[0];
    if (!data[0]) m_done = 0;
    @(posedge clk); @(negedge clk);
    evt = '0;
    if (settle) begin
      idle(2);
      if (rising) m_done = 1;
    end
  endtask

  task automatic rd_all_holds(string tag);
    for (int i = 0; i < N; i++) rd('h124 + i, DW'(mh[i]), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mc[i] = 0; mh[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R9: reset state
    rd('h120, 0, "R9 ctrl after reset");
    rd('h121, 0, "R9 status after reset");
    rd_all_holds("R9 holds after reset");

    // R2/R5: capture with timing probe
    pulse(3'b001, 5); pulse(3'b010, 2); pulse(3'b111, 3);
    ctrl_wr(1, 3'b100, 0);
    rd('h121, 0, "R5 status sampled at E3");
    rd('h121, 1, "R5 status sampled at E4");
    m_done = 1;
    rd_all_holds("R2 held values after capture");

    // R1/R7: bit kept at 1, events continue, holds unchanged
    pulse(3'b011, 4);
    idle(3);
    rd_all_holds("R7 holds kept while bit stays 1");
    rd('h121, 1, "R6 status kept while bit is 1");
    rd('h120, 1, "R8 ctrl readback 1");
    ctrl_wr(1, 3'b000, 1);
    rd_all_holds("R1 rewrite of 1 starts no capture");

    // R6/R8: drop bit with upper bits set
    ctrl_wr('hFE, 3'b000, 1);
    rd('h121, 0, "R6 status cleared by writing 0");
    rd('h120, 0, "R8 upper write bits ignored");
    rd_all_holds("R7 holds kept after dropping bit");
    wr('h121, 1);
    rd('h121, 0, "R8 status write ignored");

    // R3: events in the capture cycle
    ctrl_wr('hFF, 3'b101, 1);
    rd_all_holds("R3 capture excludes same-cycle events");
    rd('h120, 1, "R8 ctrl reads only bit 0");
    rd('h121, 1, "R6 status set after new capture");
    ctrl_wr(0, 3'b000, 1);
    ctrl_wr(1, 3'b000, 1);
    rd_all_holds("R3 same-cycle events counted in new interval");

    // R4: saturation, then capture from a pinned counter
    pulse(3'b001, 300);
    ctrl_wr(0, 3'b000, 1);
    ctrl_wr(1, 3'b001, 1);
    rd('h124, MAXV, "R4 counter saturates at all-ones");
    ctrl_wr(0, 3'b000, 1);
    ctrl_wr(1, 3'b000, 1);
    rd('h124, 1, "R4 capture clears a saturated counter");

    // R8: unmapped addresses
    rd('h122, 0, "R8 unmapped 0x122");
    rd('h124 + N, 0, "R8 unmapped after holds");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 missing read data actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule